// File: doc/BRIEF.md
# Read-Preamble Sampling Phase Trainer

This block chooses the clock phase used to sample one serial-flash data line. During every read, right after the dummy cycles, the flash drives a known learning pattern. The block receives sixteen copies of the incoming line, each taken on a different candidate clock phase. While the learn window is open, it compares every copy bit by bit against a programmed reference pattern. Any copy that disagrees even once is marked as failing.

When the learn window closes, the passing copies form a mask. The block picks the centre of the widest contiguous group of passing phases. It samples the read data through that phase from the very first read-data cycle. The choice is held until the next learn window closes. Training therefore repeats on every read and follows drift with no stored pattern in the flash.

Control is a small state machine with two states. `TS_IDLE` covers all non-learn cycles. `TS_LEARN` is entered on the first learn cycle and covers the rest of the window. The transitions are:
- start: `TS_IDLE` to `TS_LEARN` when the phase code is learn.
- hold: `TS_LEARN` to `TS_LEARN` while the code stays learn.
- commit: `TS_LEARN` to `TS_IDLE` on the first cycle whose code is anything else. This publishes the result.
- rest: `TS_IDLE` to `TS_IDLE` otherwise.

Top module: `pst_phase_trainer`

## Requirements
- R1: An active-high synchronous reset sets `sel_phase` to 0, `pass_mask` to 0, `no_pass_err` to 0 and `rd_valid` to 0.
- R2: `xfer_phase` codes are 0 idle, 1 command, 2 address, 3 mode, 4 dummy, 5 learn, 6 read data, and 7 is treated as idle. The learn window is a run of consecutive cycles with code 5. All per-phase mismatch flags are cleared in its first cycle, so results from an earlier window never carry over.
- R3: The effective pattern length L is `pat_len` clamped to the range 8..32. In learn cycle k, counted from 0, each copy is compared with `ref_pattern[L-1-k]`, so the comparison runs most significant bit first. Learn cycles with k >= L are ignored.
- R4: `pass_mask[i]` is 1 exactly when copy i matched every compared bit of the window. The mask is published at the clock edge that ends the first cycle after the window (the commit).
- R5: On a commit with at least one passing phase, `sel_phase` becomes start + (len-1)/2 of the longest contiguous run of 1s in the mask. Index 15 and index 0 are not adjacent. Equal-length runs resolve to the lowest-indexed run.
- R6: On a commit with no passing phase, `no_pass_err` becomes 1 and `sel_phase` keeps its previous value. A later commit with a passing phase clears `no_pass_err`.
- R7: In every cycle with code 6, `samp_bits[p]` is captured into `rd_bit` and `rd_valid` is 1 at the next edge. p is the phase chosen by the latest learn window, including a commit made in that same cycle. `rd_valid` is 0 after any cycle with another code.
- R8: `sel_phase`, `pass_mask` and `no_pass_err` change only at a commit edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| xfer_phase | input | 3 | Current transaction phase code (R2) |
| samp_bits | input | 16 | Data line sampled on each of the 16 candidate phases |
| ref_pattern | input | 32 | Reference learning pattern, low L bits used |
| pat_len | input | 6 | Pattern length setting, clamped to 8..32 |
| sel_phase | output | 4 | Selected sampling phase |
| pass_mask | output | 16 | Per-phase pass result of the last window |
| no_pass_err | output | 1 | Last window had no passing phase |
| rd_bit | output | 1 | Read data sampled on the selected phase |
| rd_valid | output | 1 | `rd_bit` holds a read-data sample |

## Verification
The mask, selection and error flag are due one edge after the first non-learn cycle, which is normally the first read cycle. The bench model publishes them on that same edge and compares all three at each falling edge. The read sample is due one edge after each read-data cycle and must already use the new phase from the first of those cycles; the model applies the same one-edge latency. After each transaction the bench also checks hand-computed values for the tie, even-run, no-wrap, clamp and ignored-tail cases, sampled only after the commit edge.

// File: rtl/pst_pkg.sv
package pst_pkg;

    localparam int PST_NPH     = 16;
    localparam int PST_PAT_MAX = 32;
    localparam int PST_LEN_MIN = 8;

    typedef enum logic [2:0] {
        XP_IDLE  = 3'd0,
        XP_CMD   = 3'd1,
        XP_ADDR  = 3'd2,
        XP_MODE  = 3'd3,
        XP_DUMMY = 3'd4,
        XP_LEARN = 3'd5,
        XP_READ  = 3'd6,
        XP_RSVD  = 3'd7
    } xfer_ph_e;

    typedef enum logic {
        TS_IDLE  = 1'b0,
        TS_LEARN = 1'b1
    } trn_st_e;

endpackage

// File: rtl/pst_lane_cmp.sv
module pst_lane_cmp #(
    parameter int NPH = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           upd,
    input  logic           clr,
    input  logic           cmp_en,
    input  logic           ref_bit,
    input  logic [NPH-1:0] samp,
    output logic [NPH-1:0] miss
);

    // One sticky mismatch flag per candidate phase.
    for (genvar g = 0; g < NPH; g++) begin : g_lane
        logic flag_q;
        logic bad_now;

        assign bad_now = cmp_en & (samp[g] ^ ref_bit);

        always_ff @(posedge clk) begin
            if (rst) begin
                flag_q <= 1'b0;
            end else if (upd) begin
                flag_q <= (clr ? 1'b0 : flag_q) | bad_now;
            end
        end

        assign miss[g] = flag_q;
    end

endmodule

// File: rtl/pst_centre_pick.sv
module pst_centre_pick #(
    parameter int NPH  = 16,
    localparam int PH_W  = $clog2(NPH),
    localparam int CNT_W = $clog2(NPH + 1)
) (
    input  logic [NPH-1:0]  pass,
    output logic [PH_W-1:0] pick,
    output logic            any
);

    logic [CNT_W-1:0] run_len;
    logic [CNT_W-1:0] best_len;
    logic [PH_W-1:0]  run_start;
    logic [PH_W-1:0]  best_start;
    logic [CNT_W-1:0] half;

    // Linear scan; a strictly longer run is needed to replace the best,
    // so the lowest-indexed run wins ties. No wraparound.
    always_comb begin
        run_len    = '0;
        best_len   = '0;
        run_start  = '0;
        best_start = '0;
        for (int i = 0; i < NPH; i++) begin
            if (pass[i]) begin
                if (run_len == '0) begin
                    run_start = PH_W'(i);
                end
                run_len = run_len + 1'b1;
                if (run_len > best_len) begin
                    best_len   = run_len;
                    best_start = run_start;
                end
            end else begin
                run_len = '0;
            end
        end
    end

    assign any  = |pass;
    assign half = (best_len == '0) ? '0 : ((best_len - 1'b1) >> 1);
    assign pick = best_start + half[PH_W-1:0];

endmodule

// File: rtl/pst_phase_trainer.sv
module pst_phase_trainer
    import pst_pkg::*;
#(
    parameter int NPH     = PST_NPH,
    parameter int PAT_MAX = PST_PAT_MAX,
    parameter int LEN_MIN = PST_LEN_MIN,
    localparam int PH_W   = $clog2(NPH),
    localparam int LEN_W  = $clog2(PAT_MAX + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2:0]         xfer_phase,
    input  logic [NPH-1:0]     samp_bits,
    input  logic [PAT_MAX-1:0] ref_pattern,
    input  logic [LEN_W-1:0]   pat_len,
    output logic [PH_W-1:0]    sel_phase,
    output logic [NPH-1:0]     pass_mask,
    output logic               no_pass_err,
    output logic               rd_bit,
    output logic               rd_valid
);

    xfer_ph_e         ph_in;
    trn_st_e          state_q;
    trn_st_e          state_d;
    logic             learn_now;
    logic             learn_start;
    logic             commit;
    logic [LEN_W-1:0] len_eff;
    logic [LEN_W-1:0] bit_cnt;
    logic [LEN_W-1:0] cnt_cur;
    logic [LEN_W-1:0] ref_idx;
    logic             cmp_en;
    logic             ref_bit;
    logic [NPH-1:0]   miss_flags;
    logic [PH_W-1:0]  pick_ph;
    logic             any_pass;
    logic [PH_W-1:0]  eff_ph;

    assign ph_in       = xfer_ph_e'(xfer_phase);
    assign learn_now   = (ph_in == XP_LEARN);
    assign learn_start = learn_now && (state_q == TS_IDLE);
    assign commit      = (state_q == TS_LEARN) && !learn_now;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TS_IDLE:  state_d = learn_now ? TS_LEARN : TS_IDLE;
            TS_LEARN: state_d = learn_now ? TS_LEARN : TS_IDLE;
            default:  state_d = TS_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Effective pattern length, clamped into the supported range.
    always_comb begin
        if (pat_len < LEN_W'(LEN_MIN)) begin
            len_eff = LEN_W'(LEN_MIN);
        end else if (pat_len > LEN_W'(PAT_MAX)) begin
            len_eff = LEN_W'(PAT_MAX);
        end else begin
            len_eff = pat_len;
        end
    end

    // Bit position within the learn window, MSB of the pattern first.
    assign cnt_cur = learn_start ? '0 : bit_cnt;
    assign cmp_en  = learn_now && (cnt_cur < len_eff);
    assign ref_idx = cmp_en ? (len_eff - 1'b1 - cnt_cur) : '0;

    always_comb begin
        ref_bit = 1'b0;
        for (int j = 0; j < PAT_MAX; j++) begin
            if (ref_idx == LEN_W'(j)) begin
                ref_bit = ref_pattern[j];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt <= '0;
        end else if (learn_now) begin
            bit_cnt <= cmp_en ? (cnt_cur + 1'b1) : cnt_cur;
        end
    end

    pst_lane_cmp #(
        .NPH(NPH)
    ) u_cmp (
        .clk    (clk),
        .rst    (rst),
        .upd    (learn_now),
        .clr    (learn_start),
        .cmp_en (cmp_en),
        .ref_bit(ref_bit),
        .samp   (samp_bits),
        .miss   (miss_flags)
    );

    pst_centre_pick #(
        .NPH(NPH)
    ) u_pick (
        .pass(~miss_flags),
        .pick(pick_ph),
        .any (any_pass)
    );

    // The first read cycle already uses the freshly chosen phase.
    assign eff_ph = (commit && any_pass) ? pick_ph : sel_phase;

    // Output registers.
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_phase   <= '0;
            pass_mask   <= '0;
            no_pass_err <= 1'b0;
            rd_bit      <= 1'b0;
            rd_valid    <= 1'b0;
        end else begin
            if (commit) begin
                pass_mask   <= ~miss_flags;
                no_pass_err <= !any_pass;
                if (any_pass) begin
                    sel_phase <= pick_ph;
                end
            end
            rd_valid <= (ph_in == XP_READ);
            if (ph_in == XP_READ) begin
                rd_bit <= samp_bits[eff_ph];
            end
        end
    end

    // Assertions
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (sel_phase == '0) && (pass_mask == '0) && !no_pass_err && !rd_valid);

    a_r4_err_matches_mask: assert property (@(posedge clk) disable iff (rst)
        commit |=> (no_pass_err == (pass_mask == '0)));

    a_r5_sel_in_passing: assert property (@(posedge clk) disable iff (rst)
        (commit && any_pass) |=> pass_mask[sel_phase]);

    a_r6_hold_on_fail: assert property (@(posedge clk) disable iff (rst)
        (commit && !any_pass) |=> (sel_phase == $past(sel_phase)));

    a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
        (ph_in == XP_READ) |=> rd_valid);

    a_r7_valid_drops: assert property (@(posedge clk) disable iff (rst)
        (ph_in != XP_READ) |=> !rd_valid);

    a_r8_quiet_between: assert property (@(posedge clk) disable iff (rst)
        !commit |=> ($stable(sel_phase) && $stable(pass_mask) && $stable(no_pass_err)));

endmodule

// File: tb/sim_pst_phase_trainer.sv
module sim_pst_phase_trainer;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  ph;
    logic [15:0] samp;
    logic [31:0] refp;
    logic [5:0]  plen;
    logic [3:0]  sel_phase;
    logic [15:0] pass_mask;
    logic        no_pass_err;
    logic        rd_bit;
    logic        rd_valid;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit running = 0;

    // Reference model state
    int          m_sel, m_err, m_cnt;
    bit          m_inl, m_cm, m_rv, m_rd;
    logic [15:0] m_mask, m_mism;

    pst_phase_trainer u0 (
        .clk        (clk),
        .rst        (rst),
        .xfer_phase (ph),
        .samp_bits  (samp),
        .ref_pattern(refp),
        .pat_len    (plen),
        .sel_phase  (sel_phase),
        .pass_mask  (pass_mask),
        .no_pass_err(no_pass_err),
        .rd_bit     (rd_bit),
        .rd_valid   (rd_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int clamp_len(input logic [5:0] v);
        if (v < 8)  return 8;
        if (v > 32) return 32;
        return int'(v);
    endfunction

    // Widest window first, lowest start first.
    function automatic int centre_of(input logic [15:0] p);
        for (int w = 16; w >= 1; w--) begin
            for (int s = 0; s + w <= 16; s++) begin
                bit ok;
                ok = 1'b1;
                for (int k = s; k < s + w; k++) if (!p[k]) ok = 1'b0;
                if (ok) return s + (w - 1) / 2;
            end
        end
        return -1;
    endfunction

    always @(posedge clk) begin : model
        int eff;
        int len;
        if (rst) begin
            m_sel = 0; m_err = 0; m_cnt = 0; m_inl = 0; m_cm = 0;
            m_rv = 0; m_rd = 0; m_mask = '0; m_mism = '0;
        end else begin
            eff  = m_sel;
            len  = clamp_len(plen);
            m_cm = 0;
            if (ph == 3'd5) begin
                if (!m_inl) begin
                    m_mism = '0;
                    m_cnt  = 0;
                end
                if (m_cnt < len) begin
                    for (int i = 0; i < 16; i++)
                        if (samp[i] != refp[len-1-m_cnt]) m_mism[i] = 1'b1;
                    m_cnt++;
                end
                m_inl = 1;
            end else if (m_inl) begin
                m_mask = ~m_mism;
                m_err  = (m_mask == 16'h0) ? 1 : 0;
                if (m_err == 0) m_sel = centre_of(m_mask);
                eff   = m_sel;
                m_inl = 0;
                m_cm  = 1;
            end
            m_rv = (ph == 3'd6);
            if (ph == 3'd6) m_rd = samp[eff];
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s act=%0d exp=%0d at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    // Every-clock comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (running && !rst) begin
            chk("R4", "pass_mask", int'(pass_mask), int'(m_mask));
            if (m_cm) chk("R5", "sel_phase", int'(sel_phase), m_sel);
            else      chk("R8", "sel_phase", int'(sel_phase), m_sel);
            chk("R6", "no_pass_err", int'(no_pass_err), m_err);
            chk("R7", "rd_valid", int'(rd_valid), int'(m_rv));
            if (m_rv) chk("R7", "rd_bit", int'(rd_bit), int'(m_rd));
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    task automatic put(input logic [2:0] p, input logic [15:0] s);
        @(negedge clk);
        ph   = p;
        samp = s;
    endtask

    task automatic xfer(input logic [31:0] r, input logic [5:0] pl, input logic [15:0] ps,
                        input bit late, input int extra, input int nread);
        int len;
        len = clamp_len(pl);
        put(3'd1, 16'($urandom));
        refp = r;
        plen = pl;
        put(3'd1, 16'($urandom));
        put(3'd2, 16'($urandom));
        put(3'd2, 16'($urandom));
        put(3'd3, 16'($urandom));
        put(3'd4, 16'($urandom));
        put(3'd4, 16'($urandom));
        for (int k = 0; k < len + extra; k++) begin
            logic [15:0] s;
            if (k < len) begin
                for (int i = 0; i < 16; i++) begin
                    bit bad;
                    bad  = !ps[i] && (!late || k == len - 1);
                    s[i] = r[len-1-k] ^ bad;
                end
            end else begin
                s = 16'($urandom);
            end
            put(3'd5, s);
        end
        for (int n = 0; n < nread; n++) put(3'd6, 16'($urandom));
        put(3'd7, 16'($urandom));
        put(3'd0, 16'h0);
    endtask

    task automatic expect_res(input string req, input int sel, input int mask, input int err);
        chk(req, "final sel_phase", int'(sel_phase), sel);
        chk(req, "final pass_mask", int'(pass_mask), mask);
        chk(req, "final no_pass_err", int'(no_pass_err), err);
    endtask

    initial begin
        rst  = 1'b1;
        ph   = 3'd0;
        samp = '0;
        refp = '0;
        plen = 6'd8;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "reset sel_phase", int'(sel_phase), 0);
        chk("R1", "reset pass_mask", int'(pass_mask), 0);
        chk("R1", "reset no_pass_err", int'(no_pass_err), 0);
        chk("R1", "reset rd_valid", int'(rd_valid), 0);
        rst     = 1'b0;
        running = 1;

        xfer(32'hDEADBEEF, 6'd8,  16'hFFFF, 0, 0, 4);  expect_res("R5", 7, 16'hFFFF, 0);
        xfer(32'h12345678, 6'd32, 16'h00F8, 0, 0, 3);  expect_res("R5", 5, 16'h00F8, 0);
        xfer(32'h0000A5C3, 6'd16, 16'h0E07, 0, 0, 3);  expect_res("R5", 1, 16'h0E07, 0);
        xfer(32'h00000F0F, 6'd12, 16'h3C00, 0, 0, 3);  expect_res("R5", 11, 16'h3C00, 0);
        xfer(32'hCAFEF00D, 6'd9,  16'h0000, 0, 0, 3);  expect_res("R6", 11, 16'h0000, 1);
        xfer(32'h0000005A, 6'd8,  16'h8001, 0, 0, 3);  expect_res("R2", 0, 16'h8001, 0);
        xfer(32'h000000B4, 6'd3,  16'h00FF, 1, 2, 3);  expect_res("R3", 3, 16'h00FF, 0);
        xfer(32'h9ABCDEF1, 6'd40, 16'hF000, 1, 2, 3);  expect_res("R3", 13, 16'hF000, 0);
        xfer(32'h000002C7, 6'd10, 16'h0FF0, 0, 6, 3);  expect_res("R3", 7, 16'h0FF0, 0);
        xfer(32'h000F1E2D, 6'd20, 16'hFFFE, 1, 0, 5);  expect_res("R4", 8, 16'hFFFE, 0);

        running = 0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1", "re-reset sel_phase", int'(sel_phase), 0);
        chk("R1", "re-reset pass_mask", int'(pass_mask), 0);
        rst = 1'b0;
        @(negedge clk);
        finish_run();
    end

endmodule